// File: doc/BRIEF.md
# Injection-Aligned Enable Window Divider

This block runs on a fast oscillator clock. It divides that clock by a programmable value D to produce a pair of one-cycle enable windows in every reference period. A downstream time-to-digital converter uses the windows to measure two oscillator periods. The first window of each pair is meant to cover the oscillator cycle in which the injection pulse arrives. The second window covers an ordinary free-running cycle, half a period later. A converter measuring both windows can then take their difference to estimate the tuning error.

A single-cycle marker, `inj_i`, flags the injected cycle. At each marker, a detect register records whether the first window was open in that cycle. The cycle after the marker is called a reference tick. An alignment controller looks at the detect register on each reference tick. When the window missed, the controller requests a slip, which delays the whole window sequence by one oscillator cycle. After a slip, the controller ignores a programmable number of ticks to let the result settle. When the window hits on a set number of consecutive ticks, the controller reports lock and stops stepping until it is told to restart.

Top module: `inj_window_divider`

## Requirements
- R1: The effective divide value D equals `div_i`, and `div_i` values 0 and 1 are treated as 2. With no slip in progress, `en_first_o` is high once every D oscillator cycles.
- R2: Within each period of D cycles, `en_o` is high in exactly two cycles, each a single cycle long. The first is the cycle in which `en_first_o` is high. The second comes floor(D/2) cycles later, and `en_first_o` is low in it.
- R3: A new `div_i` takes effect only at the last cycle of a period. The period already in progress finishes with its old length.
- R4: `hit_o` changes only at clock edges where `inj_i` is high. At such an edge it takes the value `en_first_o` had in that cycle. It is 0 after reset.
- R5: In the search state, a reference tick with `hit_o` at 0 raises `slip_o` for one cycle, in the cycle after the tick. The window sequence is then delayed by exactly one cycle. The held cycle is the first cycle from the slip onward in which `en_o` is low, so no window is ever stretched.
- R6: After a slip, the next `settle_i` reference ticks are ignored: they cause no slip and make no progress toward lock. If `settle_i` is 0, the very next tick is evaluated.
- R7: `locked_o` rises in the cycle after the tick that completes LOCK_N consecutive evaluated ticks with `hit_o` at 1. An evaluated miss clears the streak.
- R8: While `locked_o` is high, no slip is issued, whatever `hit_o` shows. A cycle with `restart_i` high returns the controller to search with the streak cleared, and `locked_o` is low from the next cycle on.
- R9: In the cycle in which reset is released, `locked_o`, `hit_o` and `slip_o` are low, and `en_o` and `en_first_o` are high because the counter is at phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | 7 | Oscillator cycles per reference period (2 to 127) |
| settle_i | input | SETTLE_W | Reference ticks to ignore after each slip |
| inj_i | input | 1 | High for the oscillator cycle that contains the injection pulse |
| restart_i | input | 1 | Leave lock and resume the alignment search |
| en_o | output | 1 | Enable window (two per reference period) |
| en_first_o | output | 1 | Marks the first window of each pair |
| hit_o | output | 1 | Detect register: the first window covered the last injected cycle |
| slip_o | output | 1 | One-cycle slip request from the controller |
| locked_o | output | 1 | Alignment found and held |

## Verification
The bench targets the following corner cases:
- Out-of-range and extreme divide values (0, 1, 2 and 127). A wrong clamp would show up as a period of 0, 1 or 128 cycles.
- A divide change issued mid-period. An early load would cut that period short.
- Injection phases from 0 up to D-1, with settle counts both zero and nonzero. A controller that slips by the wrong step, evaluates ignored ticks or miscounts the streak would produce the wrong number of slips, irregular spacing between slips, or lock at the wrong tick.
- After lock, the injection phase is shifted and restart is exercised. A controller that keeps stepping while locked, or one that ignores restart, is caught there.

// File: rtl/injwin_pkg.sv
package injwin_pkg;

    localparam int DIV_W   = 7;
    localparam int DIV_MIN = 2;

    typedef enum logic [1:0] {
        ALN_SEARCH = 2'd0,
        ALN_SETTLE = 2'd1,
        ALN_LOCKED = 2'd2
    } aln_state_e;

    typedef struct packed {
        logic en;
        logic first;
    } win_t;

    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] d);
        return (d < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : d;
    endfunction

endpackage

// File: rtl/inj_window_counter.sv
module inj_window_counter
    import injwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    input  logic             slip_req_i,
    output win_t             win_o
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] half;
    logic             pend_q;
    logic             terminal;
    logic             hold_now;

    assign half         = div_q >> 1;
    assign terminal     = (cnt_q == div_q - DIV_W'(1));
    assign win_o.first  = (cnt_q == '0);
    assign win_o.en     = win_o.first || (cnt_q == half);
    // a slip is applied only in a cycle with no open window
    assign hold_now     = (pend_q || slip_req_i) && !win_o.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            div_q  <= clamp_div(div_i);
            pend_q <= 1'b0;
        end else begin
            pend_q <= (pend_q || slip_req_i) && win_o.en;
            if (!hold_now) begin
                if (terminal) begin
                    cnt_q <= '0;
                    div_q <= clamp_div(div_i);
                end else begin
                    cnt_q <= cnt_q + DIV_W'(1);
                end
            end
        end
    end

    AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (rst)
        div_q >= DIV_W'(DIV_MIN)); // R1
    AST_FIRST_SINGLE: assert property (@(posedge clk) disable iff (rst)
        win_o.first |=> !win_o.first); // R2
    AST_DIV_AT_TC: assert property (@(posedge clk) disable iff (rst)
        !(terminal && !hold_now) |=> $stable(div_q)); // R3
    AST_SLIP_HOLD: assert property (@(posedge clk) disable iff (rst)
        hold_now |=> (cnt_q == $past(cnt_q))); // R5

endmodule

// File: rtl/inj_detect.sv
module inj_detect (
    input  logic clk,
    input  logic rst,
    input  logic inj_i,
    input  logic first_i,
    output logic hit_o,
    output logic tick_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hit_o  <= 1'b0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= inj_i;
            if (inj_i) begin
                hit_o <= first_i;
            end
        end
    end

    AST_HIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !inj_i |=> $stable(hit_o)); // R4

endmodule

// File: rtl/inj_align_ctrl.sv
module inj_align_ctrl
    import injwin_pkg::*;
#(
    parameter int LOCK_N   = 4,
    parameter int SETTLE_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic                hit_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic                restart_i,
    output logic                slip_o,
    output logic                locked_o
);
    localparam int STRK_W = $clog2(LOCK_N + 1);

    aln_state_e          state_q;
    logic [STRK_W-1:0]   streak_q;
    logic [SETTLE_W-1:0] wait_q;

    assign locked_o = (state_q == ALN_LOCKED);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ALN_SEARCH;
            streak_q <= '0;
            wait_q   <= '0;
            slip_o   <= 1'b0;
        end else begin
            slip_o <= 1'b0;
            if (restart_i) begin
                state_q  <= ALN_SEARCH;
                streak_q <= '0;
            end else if (tick_i) begin
                case (state_q)
                    ALN_SEARCH: begin
                        if (hit_i) begin
                            if (streak_q == STRK_W'(LOCK_N - 1)) begin
                                state_q  <= ALN_LOCKED;
                                streak_q <= '0;
                            end else begin
                                streak_q <= streak_q + STRK_W'(1);
                            end
                        end else begin
                            streak_q <= '0;
                            slip_o   <= 1'b1;
                            wait_q   <= settle_i;
                            state_q  <= (settle_i == '0) ? ALN_SEARCH : ALN_SETTLE;
                        end
                    end
                    ALN_SETTLE: begin
                        wait_q <= wait_q - SETTLE_W'(1);
                        if (wait_q == SETTLE_W'(1)) begin
                            state_q <= ALN_SEARCH;
                        end
                    end
                    default: state_q <= ALN_LOCKED;
                endcase
            end
        end
    end

    AST_SLIP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        slip_o |=> !slip_o); // R5
    AST_SLIP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        slip_o |-> $past(tick_i && !hit_i)); // R5
    AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (rst)
        locked_o |=> !slip_o); // R8
    AST_RESTART_DROP: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> !locked_o); // R8

endmodule

// File: rtl/inj_window_divider.sv
module inj_window_divider
    import injwin_pkg::*;
#(
    parameter int LOCK_N   = 4,
    parameter int SETTLE_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DIV_W-1:0]    div_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic                inj_i,
    input  logic                restart_i,
    output logic                en_o,
    output logic                en_first_o,
    output logic                hit_o,
    output logic                slip_o,
    output logic                locked_o
);
    win_t win;
    logic tick;

    inj_window_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .div_i      (div_i),
        .slip_req_i (slip_o),
        .win_o      (win)
    );

    inj_detect u_det (
        .clk     (clk),
        .rst     (rst),
        .inj_i   (inj_i),
        .first_i (win.first),
        .hit_o   (hit_o),
        .tick_o  (tick)
    );

    inj_align_ctrl #(
        .LOCK_N   (LOCK_N),
        .SETTLE_W (SETTLE_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .hit_i     (hit_o),
        .settle_i  (settle_i),
        .restart_i (restart_i),
        .slip_o    (slip_o),
        .locked_o  (locked_o)
    );

    assign en_o       = win.en;
    assign en_first_o = win.first;

endmodule

// File: tb/inj_window_divider_bench.sv
`timescale 1ns/1ps
module inj_window_divider_bench;
    localparam int LOCKN = 4;
    localparam int SW    = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [6:0]    div_i;
    logic [SW-1:0] settle_i;
    logic          inj_i;
    logic          restart_i;
    logic          en_o, en_first_o, hit_o, slip_o, locked_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int run_c;
    int run_inj;

    always #2 clk = ~clk;

    inj_window_divider #(.LOCK_N(LOCKN), .SETTLE_W(SW)) u_inj_window_divider (
        .clk(clk), .rst(rst), .div_i(div_i), .settle_i(settle_i), .inj_i(inj_i),
        .restart_i(restart_i), .en_o(en_o), .en_first_o(en_first_o), .hit_o(hit_o),
        .slip_o(slip_o), .locked_o(locked_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog R1..: actual=%0d expected=<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_div(input int v);
        return (v < 2) ? 2 : v;
    endfunction

    task automatic do_reset(input int d, input int s);
        rst = 1'b1; inj_i = 1'b0; restart_i = 1'b0;
        div_i = 7'(d); settle_i = SW'(s);
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // measure from current or next en_first, ending on the following en_first
    task automatic measure_period(input int d_exp, input string tag);
        int period = 0;
        int ens = 0;
        int secpos = -1;
        int guard = 0;
        while (!en_first_o && guard < 400) begin @(negedge clk); guard++; end
        while (period < 300) begin
            @(negedge clk);
            period++;
            if (en_first_o) break;
            if (en_o) begin ens++; secpos = period; end
        end
        check(period == d_exp, {"R1 period ", tag}, period, d_exp);
        check(ens == 1 && secpos == d_exp / 2, {"R2 second window ", tag}, secpos, d_exp / 2);
    endtask

    task automatic apply_div(input int v);
        div_i = 7'(v);
        do @(negedge clk); while (!en_first_o);
        measure_period(eff_div(v), $sformatf("div=%0d", v));
    endtask

    // alignment run from reset; injection at absolute phase k every d cycles
    task automatic run_lock(input int d, input int s, input int k);
        int slips = 0;
        int last_slip = 0;
        int lock_at = -1;
        bit spacing_ok = 1'b1;
        int misalign = 0;
        int exp_lock;
        do_reset(d, s);
        run_c = 0; run_inj = 0;
        while (run_c < 20000) begin
            if (slip_o) begin
                if (slips == 0) begin
                    if (run_inj != 1) spacing_ok = 1'b0;
                end else if (run_inj - last_slip != s + 1) spacing_ok = 1'b0;
                last_slip = run_inj;
                slips++;
            end
            if (locked_o && lock_at < 0) lock_at = run_inj;
            if (lock_at >= 0 && run_inj >= lock_at + 3) break;
            inj_i = (run_c % d == k);
            if (inj_i) begin
                run_inj++;
                if (lock_at >= 0 && !en_first_o) misalign++;
            end
            @(negedge clk);
            run_c++;
        end
        inj_i = 1'b0;
        exp_lock = (k == 0) ? LOCKN : last_slip + s + LOCKN;
        check(slips == k, $sformatf("R5 slip count d=%0d k=%0d", d, k), slips, k);
        check(spacing_ok, $sformatf("R6 slip spacing s=%0d", s), spacing_ok, 1);
        check(lock_at == exp_lock, $sformatf("R7 lock tick d=%0d s=%0d k=%0d", d, s, k), lock_at, exp_lock);
        check(misalign == 0, "R5 window aligned to injection after lock", misalign, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));

        // R9 reset state
        do_reset(10, 0);
        check(!locked_o && !hit_o && !slip_o, "R9 flags low at reset", {locked_o, hit_o, slip_o}, 0);
        check(en_o && en_first_o, "R9 window at phase 0", {en_o, en_first_o}, 3);
        measure_period(10, "after reset");

        // R1/R2 directed corners, including clamp
        apply_div(2);
        apply_div(0);
        apply_div(1);
        apply_div(127);
        apply_div(3);
        for (int i = 0; i < 8; i++) apply_div(2 + ($urandom % 126));

        // R3 mid-period change keeps the running period
        div_i = 7'd9;
        do @(negedge clk); while (!en_first_o);
        measure_period(9, "R3 setup");
        div_i = 7'd20;
        measure_period(9, "R3 old length kept");
        measure_period(20, "R3 new length");

        // R4 hit register only samples at injection
        do_reset(6, 0);
        inj_i = 1'b1;            // cycle 0: phase 0, first window open
        @(negedge clk); inj_i = 1'b0;
        check(hit_o == 1'b1, "R4 hit on aligned injection", hit_o, 1);
        repeat (4) @(negedge clk);
        check(hit_o == 1'b1, "R4 hit holds without injection", hit_o, 1);

        // R5/R6/R7 alignment searches
        run_lock(8, 0, 0);
        run_lock(8, 0, 5);
        run_lock(4, 1, 3);
        for (int i = 0; i < 4; i++) begin
            int d = 4 + ($urandom % 37);
            run_lock(d, $urandom % 4, $urandom % d);
        end

        // R8 locked holds against a phase shift, then restart
        run_lock(8, 1, 3);
        begin
            int slips_locked = 0;
            int slips_after = 0;
            int c0 = run_c;
            for (int i = 0; i < 48; i++) begin
                if (slip_o) slips_locked++;
                inj_i = ((c0 + i) % 8 == 4);
                @(negedge clk);
            end
            inj_i = 1'b0;
            @(negedge clk); @(negedge clk);
            check(slips_locked == 0, "R8 no slip while locked", slips_locked, 0);
            check(locked_o == 1'b1, "R8 lock held after phase shift", locked_o, 1);
            check(hit_o == 1'b0, "R4 miss recorded after phase shift", hit_o, 0);
            restart_i = 1'b1;
            @(negedge clk);
            restart_i = 1'b0;
            check(locked_o == 1'b0, "R8 restart drops lock", locked_o, 0);
            for (int i = 0; i < 40; i++) begin
                if (slip_o) slips_after++;
                inj_i = (i % 8 == 2);
                @(negedge clk);
            end
            inj_i = 1'b0;
            check(slips_after >= 1, "R8 search resumes after restart", slips_after, 1);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule